// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block is the register front end for one analog-to-digital converter that sits behind a multiplexer with ten inputs. Inputs 0 to 7 are differential signal inputs. Input 8 carries a +10 V reference and input 9 a 0 V reference. A host writes one 16-bit control word that names the input and starts a single conversion. The word can also ask for a settling pause before the sample is taken. That pause is meant for the first sample after the multiplexer moves to a new input.

Once a start is accepted, the block drives the multiplexer select. It waits out the settling time if one was requested, then pulses a start strobe to the external converter. When the converter raises done, the block stores the converter's 16-bit bipolar code (±10 V full scale) in a readable data register. It also sets an end-of-conversion flag in a status register, and the host clears that flag by writing 1 to it. The settling time comes from two parameters, the clock rate in MHz and the pause length in microseconds. The default pause is 15 µs.

Top module: `adc_seq`

## Requirements
- R1: After reset, `mux_sel` is 0, `conv_start` is 0, and reads of the control, data and status registers return 0.
- R2: A write to the control register (`reg_addr` 0) with bit 0 set and an input index of 9 or less in bits 4:1 is accepted while idle. From the next cycle, `mux_sel` shows that index, status bit 0 (busy) reads 1, and a control read returns the index in bits 4:1 and the pause request in bit 15.
- R3: For an accepted start with bit 15 clear, `conv_start` is high for exactly one cycle, in the cycle right after the accepting clock edge.
- R4: For an accepted start with bit 15 set, `conv_start` rises exactly CLK_MHZ*SETTLE_US cycles later than it would without the pause.
- R5: When `conv_done` is high while the block waits for the converter, then from the next cycle the data register (`reg_addr` 1) holds `conv_data`, status bit 2 (end of conversion) reads 1, and busy reads 0.
- R6: Writing to the status register (`reg_addr` 2) with bit 2 set clears the end-of-conversion flag. A status write with bit 2 clear leaves the flag unchanged.
- R7: A start written while busy is ignored: `mux_sel` does not change and no extra `conv_start` pulse occurs.
- R8: A start with an input index of 10 or more is ignored: busy stays 0, `mux_sel` does not change, and `conv_start` stays low.
- R9: A control write with bit 0 clear changes neither `mux_sel` nor busy.
- R10: The reference inputs 8 and 9 convert like any other input.
- R11: `conv_done` while idle changes neither the data register nor the end-of-conversion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select for reads and writes: 0 control, 1 data, 2 status |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register (combinational) |
| mux_sel | output | 4 | Multiplexer input select |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_done | input | 1 | Converter conversion complete |
| conv_data | input | 16 | Converter result code |

## Verification
The bench builds the block with CLK_MHZ = 2 and SETTLE_US = 15, so the settling pause is 30 cycles. At that length the bench can count every cycle of the pause and compare the strobe delay against the undelayed case. The full default of 1500 cycles stays the setting for use. Sizing the input count at its default of ten places the valid/invalid boundary at indices 9 and 10, and the bench tests both sides of it and also index 15.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_START  = 2'd2,
    ST_WAIT   = 2'd3
  } seq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTL_GO_BIT    = 0;
  localparam int CTL_DLY_BIT   = 15;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_EOC_BIT  = 2;

endpackage

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int SETTLE_CYC = 1500,
  parameter int CNT_W      = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CNT_W'(SETTLE_CYC - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int CH_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             dly_req,
  input  logic [CH_W-1:0]  chan_req,
  input  logic             settle_expired,
  input  logic             conv_done,
  output logic             accept,
  output logic             settle_load,
  output logic             settle_run,
  output logic             capture,
  output logic             busy,
  output logic             conv_start,
  output logic             dly_q,
  output logic [CH_W-1:0]  mux_sel,
  output seq_state_e       state
);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] mux_q, mux_d;
  logic            dly_d, dly_r;
  logic            chan_ok;

  assign chan_ok = (int'(chan_req) < NUM_CH);
  assign accept  = go_req && chan_ok && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    mux_d   = mux_q;
    dly_d   = dly_r;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          mux_d   = chan_req;
          dly_d   = dly_req;
          state_d = dly_req ? ST_SETTLE : ST_START;
        end
      end
      ST_SETTLE: if (settle_expired) state_d = ST_START;
      ST_START:  state_d = ST_WAIT;
      ST_WAIT:   if (conv_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mux_q   <= '0;
      dly_r   <= 1'b0;
    end else begin
      state_q <= state_d;
      mux_q   <= mux_d;
      dly_r   <= dly_d;
    end
  end

  assign settle_load = accept && dly_req;
  assign settle_run  = (state_q == ST_SETTLE);
  assign capture     = (state_q == ST_WAIT) && conv_done;
  assign busy        = (state_q != ST_IDLE);
  assign conv_start  = (state_q == ST_START);
  assign mux_sel     = mux_q;
  assign dly_q       = dly_r;
  assign state       = state_q;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              eoc_clr,
  output logic [DATA_W-1:0] data_q,
  output logic              eoc_q
);

  logic [DATA_W-1:0] data_d, data_r;
  logic              eoc_d, eoc_r;

  always_comb begin
    data_d = data_r;
    eoc_d  = eoc_r;
    if (eoc_clr) eoc_d = 1'b0;
    if (capture) begin
      data_d = conv_data;
      eoc_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0;
      eoc_r  <= 1'b0;
    end else begin
      data_r <= data_d;
      eoc_r  <= eoc_d;
    end
  end

  assign data_q = data_r;
  assign eoc_q  = eoc_r;

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 15,
  parameter int NUM_CH    = 10,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic [3:0]        mux_sel,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data
);

  localparam int CH_W       = 4;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

  logic              go_req, dly_req, eoc_clr;
  logic [CH_W-1:0]   chan_req;
  logic              accept, settle_load, settle_run, settle_expired;
  logic              capture, busy, dly_q, eoc_q;
  logic [DATA_W-1:0] data_q;
  seq_state_e        state;
  logic              unused_wr;

  assign go_req    = wr_en && (reg_addr == ADDR_CTRL) && wr_data[CTL_GO_BIT];
  assign dly_req   = wr_data[CTL_DLY_BIT];
  assign chan_req  = wr_data[CH_W:1];
  assign eoc_clr   = wr_en && (reg_addr == ADDR_STAT) && wr_data[STAT_EOC_BIT];
  assign unused_wr = ^wr_data[14:CH_W+1];

  adc_seq_settle #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (settle_load),
    .run     (settle_run),
    .expired (settle_expired)
  );

  adc_seq_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .go_req         (go_req),
    .dly_req        (dly_req),
    .chan_req       (chan_req),
    .settle_expired (settle_expired),
    .conv_done      (conv_done),
    .accept         (accept),
    .settle_load    (settle_load),
    .settle_run     (settle_run),
    .capture        (capture),
    .busy           (busy),
    .conv_start     (conv_start),
    .dly_q          (dly_q),
    .mux_sel        (mux_sel),
    .state          (state)
  );

  adc_seq_result #(.DATA_W(DATA_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .conv_data (conv_data),
    .eoc_clr   (eoc_clr),
    .data_q    (data_q),
    .eoc_q     (eoc_q)
  );

  always_comb begin
    rd_data = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        rd_data[CTL_DLY_BIT] = dly_q;
        rd_data[CH_W:1]      = mux_sel;
      end
      ADDR_DATA: rd_data[DATA_W-1:0] = data_q;
      ADDR_STAT: begin
        rd_data[STAT_BUSY_BIT] = busy;
        rd_data[STAT_EOC_BIT]  = eoc_q;
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_e        state,
  input logic              accept,
  input logic              go_req,
  input logic              dly_req,
  input logic [3:0]        chan_req,
  input logic              busy,
  input logic              conv_start,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_data,
  input logic [3:0]        mux_sel,
  input logic              eoc_q,
  input logic              eoc_clr,
  input logic              capture,
  input logic [DATA_W-1:0] data_q
);

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mux_sel) < NUM_CH); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3

  AST_DIRECT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dly_req) |=> conv_start); // R3

  AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dly_req) |=> (!conv_start && busy)); // R4

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && conv_done) |=> (eoc_q && !busy && data_q == $past(conv_data))); // R5

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_clr && !capture) |=> !eoc_q); // R6

  AST_SEL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mux_sel)); // R7

  AST_BAD_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !busy && int'(chan_req) >= NUM_CH) |=> (!busy && $stable(mux_sel))); // R8

  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !eoc_q && !eoc_clr) |=> !eoc_q); // R11

endmodule

bind adc_seq adc_seq_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state),
  .accept     (accept),
  .go_req     (go_req),
  .dly_req    (dly_req),
  .chan_req   (chan_req),
  .busy       (busy),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .mux_sel    (mux_sel),
  .eoc_q      (eoc_q),
  .eoc_clr    (eoc_clr),
  .capture    (capture),
  .data_q     (data_q)
);

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;

  localparam int BENCH_MHZ = 2;
  localparam int BENCH_US  = 15;
  localparam int PAUSE     = 30;

  logic        clk;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [3:0]  mux_sel;
  logic        conv_start;
  logic        conv_done;
  logic [15:0] conv_data;

  int checks;
  int errors;
  int starts;
  bit finished;

  adc_seq #(.CLK_MHZ(BENCH_MHZ), .SETTLE_US(BENCH_US)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .mux_sel    (mux_sel),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_data  (conv_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && conv_start) starts <= starts + 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a;
    wr_data  = d;
    wr_en    = 1'b1;
    @(negedge clk);
    wr_en    = 1'b0;
    wr_data  = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic give_done(input logic [15:0] v);
    conv_done = 1'b1;
    conv_data = v;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input bit dly, input int ch, input bit go);
    return {dly, 10'b0, 4'(ch), go};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check("R1 mux_sel", 32'(mux_sel), 0);
    check("R1 conv_start", 32'(conv_start), 0);
    read_reg(2'd0, v); check("R1 ctrl read", 32'(v), 0);
    read_reg(2'd1, v); check("R1 data read", 32'(v), 0);
    read_reg(2'd2, v); check("R1 status read", 32'(v), 0);
  endtask

  task automatic t_direct(input int ch, input logic [15:0] val, input string tag);
    logic [15:0] v;
    int s0;
    s0 = starts;
    write_reg(2'd0, ctl(1'b0, ch, 1'b1));
    check({tag, " R2 mux_sel"}, 32'(mux_sel), 32'(ch));
    check({tag, " R3 strobe after accept"}, 32'(conv_start), 1);
    read_reg(2'd2, v); check({tag, " R2 busy"}, 32'(v[0]), 1);
    read_reg(2'd0, v); check({tag, " R2 ctrl readback"}, 32'(v), 32'(ch << 1));
    @(negedge clk);
    check({tag, " R3 strobe one cycle"}, 32'(conv_start), 0);
    give_done(val);
    read_reg(2'd1, v); check({tag, " R5 data"}, 32'(v), 32'(val));
    read_reg(2'd2, v); check({tag, " R5 status"}, 32'(v), 32'h4);
    check({tag, " R3 one strobe"}, 32'(starts - s0), 1);
    write_reg(2'd2, 16'h0004);
  endtask

  task automatic t_delay();
    logic [15:0] v;
    int k;
    write_reg(2'd0, ctl(1'b1, 5, 1'b1));
    check("R4 no strobe at accept", 32'(conv_start), 0);
    read_reg(2'd0, v); check("R2 ctrl readback pause", 32'(v), 32'h800A);
    k = 0;
    while (!conv_start && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check("R4 pause length", 32'(k), 32'(PAUSE));
    @(negedge clk);
    give_done(16'h1234);
    read_reg(2'd1, v); check("R4 data after pause", 32'(v), 32'h1234);
    write_reg(2'd2, 16'h0004);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    int s0;
    write_reg(2'd0, ctl(1'b0, 2, 1'b1));
    @(negedge clk);
    s0 = starts;
    write_reg(2'd0, ctl(1'b0, 6, 1'b1));
    check("R7 mux_sel kept", 32'(mux_sel), 2);
    repeat (3) @(negedge clk);
    check("R7 no extra strobe", 32'(starts - s0), 0);
    give_done(16'hBEEF);
    read_reg(2'd2, v); check("R7 status after done", 32'(v), 32'h4);
    write_reg(2'd2, 16'h0004);
  endtask

  task automatic t_bad_chan();
    logic [15:0] v;
    int s0;
    s0 = starts;
    write_reg(2'd0, ctl(1'b0, 10, 1'b1));
    read_reg(2'd2, v); check("R8 idx10 not busy", 32'(v), 0);
    check("R8 idx10 mux kept", 32'(mux_sel), 2);
    write_reg(2'd0, ctl(1'b0, 15, 1'b1));
    read_reg(2'd2, v); check("R8 idx15 not busy", 32'(v), 0);
    repeat (3) @(negedge clk);
    check("R8 no strobe", 32'(starts - s0), 0);
  endtask

  task automatic t_no_go();
    logic [15:0] v;
    write_reg(2'd0, ctl(1'b0, 4, 1'b0));
    check("R9 mux kept", 32'(mux_sel), 2);
    read_reg(2'd2, v); check("R9 not busy", 32'(v), 0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    write_reg(2'd0, ctl(1'b0, 1, 1'b1));
    @(negedge clk);
    give_done(16'h0F0F);
    write_reg(2'd2, 16'hFFFB);
    read_reg(2'd2, v); check("R6 zero write keeps flag", 32'(v), 32'h4);
    write_reg(2'd2, 16'h0004);
    read_reg(2'd2, v); check("R6 one write clears", 32'(v), 0);
  endtask

  task automatic t_stray_done();
    logic [15:0] v;
    give_done(16'h5555);
    read_reg(2'd2, v); check("R11 flag stays clear", 32'(v), 0);
    read_reg(2'd1, v); check("R11 data kept", 32'(v), 32'h0F0F);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; starts = 0; finished = 1'b0;
    rst_n = 1'b0; reg_addr = '0; wr_en = 1'b0; wr_data = '0;
    conv_done = 1'b0; conv_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct(3, 16'h8001, "ch3");
    t_direct(9, 16'h7FFF, "R10 ch9");
    t_direct(8, 16'h0000, "R10 ch8");
    t_delay();
    t_busy_ignore();
    t_bad_chan();
    t_no_go();
    t_clear();
    t_stray_done();
    finish_run();
  end

endmodule